// File: doc/BRIEF.md
# Serial flash target front end

This block is the device side of a four-wire serial flash link. An active-low select frames each transaction. Inside a frame the block gathers an opcode byte and, for most opcodes, a 24-bit address. It then streams data between the pins and a simple byte-wide memory port. Read data goes out one bit per serial clock, or two bits per clock in dual-output reads. Program data comes in one bit per clock, or two bits per clock in dual-input programs. For the two-bit modes the block turns the pin that normally receives into a driver, or the pin that normally drives into a receiver.

All pins are sampled in the system clock domain through a synchronizer, and serial clock edges are detected from the sampled copy. The serial clock half period must be at least 8 system clocks. Program data leaves the block as a valid/ready stream of address/data pairs. `wr_valid` stays high, with `wr_addr` and `wr_data` unchanged, until a cycle in which `wr_ready` is high. The core must accept each byte before the next byte finishes arriving on the pins, because the serial master cannot be stalled. Read data is fetched one byte ahead over a request port with a fixed latency of one cycle. When a program or an erase frame closes, a one-cycle start pulse hands the operation to the core. The core answers with its busy flag, and the block holds off standby until that flag drops.

Top module: `sflash_target_fe`

## Requirements
- R1: A frame opens on a falling `spi_cs_n` and closes on a rising one. While `spi_cs_n` is high, serial clock edges and data bits have no effect, and both output enables are low from the fourth consecutive high-select cycle onward.
- R2: The first 8 bits of a frame are the opcode, MSB first. Read is 0x03, dual read 0x3B, program 0x02, dual program 0xA2, erase 0x20 and status 0x05. All but status are followed by a 24-bit address, MSB first. Any other opcode makes the rest of the frame ignored: no output enable, no write, no start pulse.
- R3: Opcode, address and single-mode program data are taken from `spi_io0_i` on rising serial clock edges.
- R4: In read and status frames, output bits change only after falling serial clock edges. In single mode each byte goes out MSB first on `spi_io1_o`, with `spi_io1_oe` high and `spi_io0_oe` low.
- R5: In a dual read both output enables are high. Each falling edge presents one bit pair, with `spi_io1_o` carrying the more significant bit, so a byte takes 4 clocks, highest pair first.
- R6: In a dual program, each rising edge takes a bit pair, with `spi_io1_i` as the more significant bit, so a byte takes 4 clocks.
- R7: Read data for address A, A+1, A+2 and so on is requested with a one-cycle `rd_en` and `rd_addr`. `rd_data` is taken in the cycle after `rd_en`, and the address wraps modulo 2^24.
- R8: Every complete program byte produces one write with address A, A+1 and so on. `wr_addr` and `wr_data` stay stable while `wr_valid` waits for `wr_ready`.
- R9: Bits of an incomplete byte at frame end are dropped. A program frame with no complete data byte produces no write and no start pulse.
- R10: When a program frame with at least one byte closes, `op_start` pulses for one cycle with `op_erase`=0 and `op_addr` set to the frame's start address. An erase frame with a full address gives the same pulse with `op_erase`=1.
- R11: `standby` is high only while the block is deselected, idle, not pulsing `op_start`, and `core_busy` is low. The core raises `core_busy` in the cycle after `op_start`.
- R12: The status byte is 0x00 except bit 0 = `core_busy` and bit 1 = write protect asserted. It repeats for as long as the frame stays open.
- R13: `wp_active` is high exactly when `wp_n` is low. An unconnected pin is expected to be pulled high, which means not protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock from the master |
| spi_io0_i | input | 1 | Data pin 0 input (serial in; LSB of a dual pair) |
| spi_io0_o | output | 1 | Data pin 0 output value (dual read only) |
| spi_io0_oe | output | 1 | Data pin 0 output enable |
| spi_io1_i | input | 1 | Data pin 1 input (MSB of a dual program pair) |
| spi_io1_o | output | 1 | Data pin 1 output value (serial out) |
| spi_io1_oe | output | 1 | Data pin 1 output enable |
| wp_n | input | 1 | Active-low write-protect pin |
| wp_active | output | 1 | Write protect asserted, toward the core |
| core_busy | input | 1 | Core is running a self-timed operation |
| standby | output | 1 | Block is in standby |
| rd_en | output | 1 | Read request strobe |
| rd_addr | output | 24 | Read request address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_valid | output | 1 | Program byte valid |
| wr_ready | input | 1 | Core accepts the program byte |
| wr_addr | output | 24 | Program byte address |
| wr_data | output | 8 | Program byte value |
| op_start | output | 1 | One-cycle start of a self-timed operation |
| op_erase | output | 1 | Started operation is an erase (else program) |
| op_addr | output | 24 | Start address of the operation |

## Verification
A bit counter that slips, or a mode flag with the wrong value, shows at the pins within one byte time. The first data byte of a read comes back shifted or with its bit pairs swapped, or the next write arrives with a wrong value or address. A stale address register shows up as a wrong `rd_addr` or `wr_addr` on the first byte after the header. A frame state left open after the select rises shows as a missing or extra `op_start` within a few cycles of the rising select, as an output enable still high, or as `standby` staying low after the core's busy time.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_READ2  = 8'h3B;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_PROG2  = 8'hA2;
  localparam logic [7:0] OPC_ERASE  = 8'h20;
  localparam logic [7:0] OPC_STATUS = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_READ, ST_WRITE, ST_ERASE, ST_SKIP
  } frame_st_e;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_READ2, K_PROG, K_PROG2, K_ERASE, K_STATUS
  } op_kind_e;

  function automatic op_kind_e decode_op(input logic [7:0] opc);
    case (opc)
      OPC_READ:   return K_READ;
      OPC_READ2:  return K_READ2;
      OPC_PROG:   return K_PROG;
      OPC_PROG2:  return K_PROG2;
      OPC_ERASE:  return K_ERASE;
      OPC_STATUS: return K_STATUS;
      default:    return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sft_sync.sv
module sft_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sft_rx_shift.sv
module sft_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         dual,
  input  logic         d_hi,
  input  logic         d_lo,
  output logic [W-1:0] byte_q,
  output logic         done
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh_n;
  logic [CW-1:0] cnt_n;

  assign sh_n  = dual ? {sh[W-3:0], d_hi, d_lo} : {sh[W-2:0], d_lo};
  assign cnt_n = cnt + (dual ? CW'(2) : CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      byte_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (step) begin
        sh <= sh_n;
        if (cnt_n >= CW'(W)) begin
          cnt    <= '0;
          byte_q <= sh_n;
          done   <= 1'b1;
        end else begin
          cnt <= cnt_n;
        end
      end
    end
  end
endmodule

// File: rtl/sft_tx_shift.sv
module sft_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         dual,
  input  logic [W-1:0] load_byte,
  output logic         take,
  output logic         out_hi,
  output logic         out_lo
);
  localparam int LW = $clog2(W);

  logic [W-1:0]  sh;
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      left   <= '0;
      take   <= 1'b0;
      out_hi <= 1'b0;
      out_lo <= 1'b0;
    end else begin
      take <= 1'b0;
      if (clear) begin
        left   <= '0;
        out_hi <= 1'b0;
        out_lo <= 1'b0;
      end else if (step) begin
        if (left == '0) begin
          take <= 1'b1;
          if (dual) begin
            {out_hi, out_lo} <= load_byte[W-1:W-2];
            sh               <= load_byte << 2;
            left             <= LW'(W/2 - 1);
          end else begin
            out_hi <= load_byte[W-1];
            out_lo <= 1'b0;
            sh     <= load_byte << 1;
            left   <= LW'(W - 1);
          end
        end else begin
          if (dual) begin
            {out_hi, out_lo} <= sh[W-1:W-2];
            sh               <= sh << 2;
          end else begin
            out_hi <= sh[W-1];
            sh     <= sh << 1;
          end
          left <= left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sflash_target_fe.sv
module sflash_target_fe
  import sft_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_io0_i,
  output logic              spi_io0_o,
  output logic              spi_io0_oe,
  input  logic              spi_io1_i,
  output logic              spi_io1_o,
  output logic              spi_io1_oe,
  input  logic              wp_n,
  output logic              wp_active,
  input  logic              core_busy,
  output logic              standby,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              op_start,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  // pin sampling: {cs_n, sck, io1, io0}
  logic [3:0] pin_s;
  sft_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_io1_i, spi_io0_i}),
    .q(pin_s)
  );

  logic s_cs, s_sck, s_io1, s_io0;
  assign {s_cs, s_sck, s_io1, s_io0} = pin_s;

  logic p_cs, p_sck;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cs  <= 1'b1;
      p_sck <= 1'b0;
    end else begin
      p_cs  <= s_cs;
      p_sck <= s_sck;
    end
  end

  logic cs_fall, cs_rise, sck_rise, sck_fall;
  assign cs_fall  = p_cs & ~s_cs;
  assign cs_rise  = ~p_cs & s_cs;
  assign sck_rise = s_sck & ~p_sck & ~s_cs;
  assign sck_fall = ~s_sck & p_sck & ~s_cs;

  frame_st_e         state;
  op_kind_e          kind;
  logic [AB_W-1:0]   abyte;
  logic [ADDR_W-1:0] addr, base;
  logic              wrote, fetch_q, rd_pend;
  logic [7:0]        nxt_byte;
  logic [7:0]        status_byte;
  logic [ADDR_W-1:0] addr_shift;

  assign status_byte = {6'b0, ~wp_n, core_busy};

  // receive path
  logic       rx_done;
  logic [7:0] rx_byte;
  logic       rx_step, rx_clear, rx_dual;
  assign rx_step  = sck_rise && (state == ST_CMD || state == ST_ADDR || state == ST_WRITE);
  assign rx_clear = (state == ST_IDLE) || cs_fall;
  assign rx_dual  = (state == ST_WRITE) && (kind == K_PROG2);

  sft_rx_shift #(.W(8)) i_rx (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .step(rx_step), .dual(rx_dual),
    .d_hi(s_io1), .d_lo(s_io0), .byte_q(rx_byte), .done(rx_done)
  );

  // transmit path
  logic tx_take, tx_hi, tx_lo, tx_clear, tx_step, tx_dual;
  assign tx_clear = (state != ST_READ);
  assign tx_step  = sck_fall && (state == ST_READ);
  assign tx_dual  = (kind == K_READ2);

  sft_tx_shift #(.W(8)) i_tx (
    .clk(clk), .rst_n(rst_n), .clear(tx_clear), .step(tx_step), .dual(tx_dual),
    .load_byte(nxt_byte), .take(tx_take), .out_hi(tx_hi), .out_lo(tx_lo)
  );

  assign addr_shift = {addr[ADDR_W-9:0], rx_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_NONE;
      abyte    <= '0;
      addr     <= '0;
      base     <= '0;
      wrote    <= 1'b0;
      fetch_q  <= 1'b0;
      rd_pend  <= 1'b0;
      nxt_byte <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      op_start <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
    end else begin
      rd_en    <= 1'b0;
      op_start <= 1'b0;
      fetch_q  <= 1'b0;
      rd_pend  <= rd_en;
      if (rd_pend) nxt_byte <= rd_data;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      // keep one byte ready ahead of the shifter
      if (fetch_q || tx_take) begin
        if (kind == K_STATUS) begin
          nxt_byte <= status_byte;
        end else begin
          rd_en   <= 1'b1;
          rd_addr <= addr;
          addr    <= addr + ADDR_W'(1);
        end
      end

      if (cs_rise) begin
        state <= ST_IDLE;
        if ((state == ST_WRITE && wrote) || state == ST_ERASE) begin
          op_start <= 1'b1;
          op_erase <= (state == ST_ERASE);
          op_addr  <= base;
        end
      end else if (cs_fall) begin
        state <= ST_CMD;
        kind  <= K_NONE;
        abyte <= '0;
        wrote <= 1'b0;
      end else begin
        case (state)
          ST_CMD: if (rx_done) begin
            kind <= decode_op(rx_byte);
            case (decode_op(rx_byte))
              K_NONE:   state <= ST_SKIP;
              K_STATUS: begin state <= ST_READ; fetch_q <= 1'b1; end
              default:  state <= ST_ADDR;
            endcase
          end
          ST_ADDR: if (rx_done) begin
            addr  <= addr_shift;
            abyte <= abyte + 1'b1;
            if (abyte == AB_W'(ADDR_BYTES - 1)) begin
              base <= addr_shift;
              case (kind)
                K_READ, K_READ2: begin state <= ST_READ; fetch_q <= 1'b1; end
                K_PROG, K_PROG2: state <= ST_WRITE;
                K_ERASE:         state <= ST_ERASE;
                default:         state <= ST_SKIP;
              endcase
            end
          end
          ST_WRITE: if (rx_done) begin
            wr_valid <= 1'b1;
            wr_data  <= rx_byte;
            wr_addr  <= addr;
            addr     <= addr + ADDR_W'(1);
            wrote    <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign spi_io1_oe = (state == ST_READ) && !s_cs;
  assign spi_io0_oe = (state == ST_READ) && (kind == K_READ2) && !s_cs;
  assign spi_io1_o  = tx_hi;
  assign spi_io0_o  = tx_dual ? tx_lo : 1'b0;
  assign wp_active  = ~wp_n;
  assign standby    = s_cs && (state == ST_IDLE) && !op_start && !core_busy;
endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_io0_oe,
  input logic              spi_io1_oe,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              op_start,
  input logic              rd_en
);
  logic [1:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_run <= '0;
    else if (!spi_cs_n)     hi_run <= '0;
    else if (hi_run != 2'd3) hi_run <= hi_run + 1'b1;
  end

  // R1
  desel_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && hi_run == 2'd3) |-> (!spi_io0_oe && !spi_io1_oe));

  // R4
  io0_needs_io1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_io0_oe |-> spi_io1_oe);

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  // R10
  op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
endmodule

bind sflash_target_fe sft_checker #(.ADDR_W(ADDR_W)) i_sft_checker (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
  .spi_io0_oe(spi_io0_oe), .spi_io1_oe(spi_io1_oe),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .op_start(op_start), .rd_en(rd_en)
);

// File: tb/test_sflash_target_fe.sv
module test_sflash_target_fe;
  localparam int HP       = 8;
  localparam int BUSY_LEN = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sck = 1'b0, io0_i = 1'b0, io1_i = 1'b0;
  logic        io0_o, io0_oe, io1_o, io1_oe;
  logic        wp_n = 1'b1, wp_active;
  logic        core_busy, standby;
  logic        busy_force = 1'b0;
  int          busy_cnt = 0;
  logic        rd_en;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;
  logic        op_start, op_erase;
  logic [23:0] op_addr;

  int checks = 0;
  int errors = 0;
  int ops_seen = 0;
  int cs_hi = 0;
  logic [31:0] exp_wr[$];
  logic [24:0] exp_op[$];

  always #5 clk = ~clk;

  sflash_target_fe i_sflash_target_fe (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_io0_i(io0_i), .spi_io0_o(io0_o), .spi_io0_oe(io0_oe),
    .spi_io1_i(io1_i), .spi_io1_o(io1_o), .spi_io1_oe(io1_oe),
    .wp_n(wp_n), .wp_active(wp_active), .core_busy(core_busy), .standby(standby),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .op_start(op_start), .op_erase(op_erase), .op_addr(op_addr)
  );

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return (a[7:0] * 8'd7) + a[15:8] + a[23:16] + 8'h3C;
  endfunction

  // core model: one-cycle read latency, busy after a start pulse
  assign core_busy = busy_force || (busy_cnt != 0);
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem_f(rd_addr);
    if (!rst_n)            busy_cnt <= 0;
    else if (op_start)     busy_cnt <= BUSY_LEN;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    logic [31:0] ew;
    logic [24:0] eo;
    #2;
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (exp_wr.size() == 0) chk(1'b0, "R8 unexpected write", {wr_addr, wr_data}, 32'h0);
        else begin
          ew = exp_wr.pop_front();
          chk({wr_addr, wr_data} == ew, "R8 write addr/data", {wr_addr, wr_data}, ew);
        end
      end
      if (op_start) begin
        ops_seen++;
        if (exp_op.size() == 0) chk(1'b0, "R10 unexpected op_start", {7'b0, op_erase, op_addr}, 32'h0);
        else begin
          eo = exp_op.pop_front();
          chk({op_erase, op_addr} == eo, "R10 op kind/addr", {7'b0, op_erase, op_addr}, {7'b0, eo});
        end
      end
      if (cs_n) cs_hi++; else cs_hi = 0;
      if (cs_hi >= 4) chk(!io0_oe && !io1_oe, "R1 oe while deselected", {io1_oe, io0_oe}, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic hi, input logic lo, output logic r_hi, output logic r_lo);
    io1_i = hi;
    io0_i = lo;
    tick(HP);
    r_hi = io1_o;
    r_lo = io0_o;
    sck = 1'b1;
    tick(HP);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input bit dual, output logic [7:0] rx);
    logic h, l;
    if (!dual) begin
      for (int i = 7; i >= 0; i--) begin
        bit_cycle(1'b0, tx[i], h, l);
        rx[i] = h;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        bit_cycle(tx[7-2*k], tx[6-2*k], h, l);
        rx[7-2*k] = h;
        rx[6-2*k] = l;
      end
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(HP);
  endtask

  task automatic desel();
    tick(HP);
    cs_n = 1'b1;
    tick(3*HP);
  endtask

  task automatic send_hdr(input logic [7:0] opc, input logic [23:0] a);
    logic [7:0] rx;
    sel();
    xfer(opc, 1'b0, rx);
    xfer(a[23:16], 1'b0, rx);
    xfer(a[15:8], 1'b0, rx);
    xfer(a[7:0], 1'b0, rx);
  endtask

  task automatic read_frame(input logic [7:0] opc, input logic [23:0] a, input int n, input bit dual);
    logic [7:0] rx, ex;
    send_hdr(opc, a);
    for (int b = 0; b < n; b++) begin
      xfer(8'h00, dual, rx);
      ex = mem_f(a + 24'(b));
      if (dual) chk(rx == ex, "R5 dual read byte (R7 address)", {24'h0, rx}, {24'h0, ex});
      else      chk(rx == ex, "R4 single read byte (R7 address)", {24'h0, rx}, {24'h0, ex});
      if (b == 0) begin
        if (dual) chk(io1_oe && io0_oe, "R5 both pins drive", {io1_oe, io0_oe}, 2'b11);
        else      chk(io1_oe && !io0_oe, "R4 only io1 drives", {io1_oe, io0_oe}, 2'b10);
      end
    end
    desel();
  endtask

  task automatic prog_frame(input logic [7:0] opc, input logic [23:0] a, input logic [7:0] d0,
                            input int n, input bit dual, input int extra_bits);
    logic [7:0] rx;
    logic h, l;
    send_hdr(opc, a);
    for (int b = 0; b < n; b++) begin
      exp_wr.push_back({a + 24'(b), d0 + 8'(b * 37)});
      xfer(d0 + 8'(b * 37), dual, rx);
    end
    for (int e = 0; e < extra_bits; e++) bit_cycle(1'b1, 1'b1, h, l);
    if (n > 0) exp_op.push_back({1'b0, a});
    desel();
  endtask

  initial begin
    logic [7:0] rx;
    logic h, l;
    int ops0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // reset state
    chk(!io0_oe && !io1_oe, "R1 oe after reset", {io1_oe, io0_oe}, 0);
    chk(!wr_valid && !op_start && !rd_en, "R8 idle outputs after reset", {wr_valid, op_start, rd_en}, 0);
    chk(standby == 1'b1, "R11 standby after reset", standby, 1);
    chk(wp_active == 1'b0, "R13 wp inactive when high", wp_active, 0);

    // single and dual reads, including address wrap
    read_frame(8'h03, 24'h012345, 3, 1'b0);
    read_frame(8'h3B, 24'h00FFFE, 3, 1'b1);
    read_frame(8'h3B, 24'hFFFFFE, 4, 1'b1);
    read_frame(8'h03, 24'hFFFFFF, 2, 1'b0);

    // single program (R3), then busy and standby
    prog_frame(8'h02, 24'h000100, 8'h5A, 2, 1'b0, 0);
    chk(standby == 1'b0, "R11 standby held off while busy", standby, 0);
    tick(BUSY_LEN + 4);
    chk(standby == 1'b1, "R11 standby after busy ends", standby, 1);

    // dual program (R6)
    prog_frame(8'hA2, 24'hABCDEF, 8'hC3, 3, 1'b1, 0);
    tick(BUSY_LEN + 4);

    // partial trailing byte dropped (R9)
    prog_frame(8'h02, 24'h000200, 8'h81, 1, 1'b0, 5);
    tick(BUSY_LEN + 4);
    ops0 = ops_seen;
    prog_frame(8'h02, 24'h000300, 8'h00, 0, 1'b0, 4);
    chk(ops_seen == ops0, "R9 no start without a full byte", ops_seen, ops0);
    chk(exp_wr.size() == 0, "R9 all expected writes seen", exp_wr.size(), 0);

    // erase (R10)
    exp_op.push_back({1'b1, 24'h070809});
    send_hdr(8'h20, 24'h070809);
    desel();
    chk(exp_op.size() == 0, "R10 erase start seen", exp_op.size(), 0);
    tick(BUSY_LEN + 4);

    // back-pressure (R8)
    wr_ready = 1'b0;
    send_hdr(8'h02, 24'h000400);
    exp_wr.push_back({24'h000400, 8'h77});
    xfer(8'h77, 1'b0, rx);
    tick(HP);
    chk(wr_valid && wr_data == 8'h77 && wr_addr == 24'h000400, "R8 held under back-pressure",
        {wr_valid, wr_addr[22:0], wr_data}, {1'b1, 23'h000400, 8'h77});
    wr_ready = 1'b1;
    exp_op.push_back({1'b0, 24'h000400});
    desel();
    chk(exp_wr.size() == 0, "R8 held write accepted", exp_wr.size(), 0);
    tick(BUSY_LEN + 4);

    // status with busy and write protect (R12, R13)
    wp_n = 1'b0;
    busy_force = 1'b1;
    tick(2);
    chk(wp_active == 1'b1, "R13 wp asserted when low", wp_active, 1);
    sel();
    xfer(8'h05, 1'b0, rx);
    xfer(8'h00, 1'b0, rx);
    chk(rx == 8'h03, "R12 status busy+wp", rx, 8'h03);
    busy_force = 1'b0;
    wp_n = 1'b1;
    xfer(8'h00, 1'b0, rx);
    xfer(8'h00, 1'b0, rx);
    chk(rx == 8'h00, "R12 status idle", rx, 8'h00);
    desel();

    // unknown opcode (R2)
    sel();
    xfer(8'hFF, 1'b0, rx);
    xfer(8'h12, 1'b0, rx);
    chk(!io1_oe && !io0_oe, "R2 unknown opcode no drive", {io1_oe, io0_oe}, 0);
    xfer(8'h34, 1'b0, rx);
    desel();

    // clocks and data with the select high (R1)
    ops0 = ops_seen;
    for (int i = 0; i < 48; i++) bit_cycle(i[0], i[1], h, l);
    tick(4);
    chk(!wr_valid && ops_seen == ops0, "R1 no effect while deselected", {wr_valid, 8'(ops_seen - ops0)}, 0);
    chk(standby == 1'b1, "R11 standby when quiet", standby, 1);

    // a normal read still works afterwards (R2, R3)
    read_frame(8'h03, 24'h400000, 2, 1'b0);
    chk(exp_op.size() == 0 && exp_wr.size() == 0, "R10 no outstanding events", exp_op.size() + exp_wr.size(), 0);
    finish_run();
  end
endmodule